// File: doc/BRIEF.md
# Pipeline Operand Forwarding and Hazard Control

This block holds the hazard logic for a five-stage in-order pipeline. The stages run in this order: fetch, decode with register read, execute (which also computes addresses), memory access, and write-back. The block watches register numbers and write-enables as they move down the pipeline. From them it chooses the operand source for each execute-stage input, and it chooses the store-data source in the memory stage. It also decides when to hold the front of the pipeline and when to discard a wrongly fetched instruction.

A destination register number travels with its instruction until write-back. A value produced in execute can therefore be handed to the next instruction, and a value in write-back can be handed to the instruction two behind it. A load followed at once by an instruction that needs the loaded register in execute costs one bubble. A store whose data register is the loaded register needs no bubble: the loaded value passes straight into the store's memory-stage data path. Branches are predicted not taken. When the decode-stage comparator reports a taken branch, the single instruction fetched behind it is discarded.

All decisions are combinational functions of the current stage contents. The clock and reset are used only by the embedded checks.

Top module: `fwd_hazard_unit`

## Requirements
- R1: When an execute source register is nonzero and equals the memory-stage destination with its write-enable set, that operand's select (fwd_a for rs, fwd_b for rt) is 2'b10, meaning the memory-stage result.
- R2: When an execute source register is nonzero, does not match an enabled memory-stage destination, and equals an enabled write-back destination, its select is 2'b01, meaning the write-back value.
- R3: When both the memory stage and the write-back stage hold an enabled match for the same source, the select is 2'b10: the nearer stage wins.
- R4: A select is 2'b00 (register-file value) when the source register is 0, or when no enabled stage destination matches it. Register 0 never produces a match.
- R5: st_fwd is 1 exactly when the memory stage holds a store, its data register is nonzero, and that register equals an enabled write-back destination.
- R6: A load-use stall occurs when the execute stage holds an enabled load with a nonzero destination that equals the decode rs, or that equals the decode rt of a non-store. During the stall, pc_hold, ifid_hold and idex_bubble are all 1 in the same cycle.
- R7: A store in decode whose only match with the execute-stage load destination is its rt (data) register does not stall.
- R8: When branch_taken is 1 and no stall occurs, ifid_flush is 1 and all three hold/bubble outputs are 0. With branch_taken at 0, ifid_flush is 0.
- R9: When a stall and branch_taken occur in the same cycle, ifid_flush is 0 and the stall outputs are 1.
- R10: With all stage write-enables, load/store flags and branch_taken at 0, every output is 0. This includes the reset state of the surrounding pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used only by the embedded checks |
| rst | input | 1 | Synchronous active-high reset, disables the checks |
| id_rs | input | REG_W | Decode-stage first source register |
| id_rt | input | REG_W | Decode-stage second source register |
| id_is_store | input | 1 | Decode stage holds a store (rt is store data) |
| ex_rs | input | REG_W | Execute-stage first source register |
| ex_rt | input | REG_W | Execute-stage second source register |
| ex_rd | input | REG_W | Execute-stage destination register |
| ex_wen | input | 1 | Execute-stage register write-enable |
| ex_is_load | input | 1 | Execute stage holds a load |
| mem_rd | input | REG_W | Memory-stage destination register |
| mem_wen | input | 1 | Memory-stage register write-enable |
| mem_is_store | input | 1 | Memory stage holds a store |
| mem_st_reg | input | REG_W | Memory-stage store data register |
| wb_rd | input | REG_W | Write-back destination register |
| wb_wen | input | 1 | Write-back register write-enable |
| branch_taken | input | 1 | Decode-stage branch resolved as taken |
| fwd_a | output | 2 | Execute operand A source: 00 file, 01 write-back, 10 memory stage |
| fwd_b | output | 2 | Execute operand B source, same encoding |
| st_fwd | output | 1 | Store data taken from the write-back value |
| pc_hold | output | 1 | Keep the program counter |
| ifid_hold | output | 1 | Keep the fetch/decode register |
| idex_bubble | output | 1 | Load a no-op with cleared write-enables into execute |
| ifid_flush | output | 1 | Discard the instruction in the fetch/decode register |

## Verification
The checks assume that the stage inputs are stable around each rising edge. They also assume that a stage with its write-enable cleared may carry any destination number. They make no assumption about how the stages follow one another, so any input combination is legal. The stimulus changes inputs only on falling edges and sweeps every combination of register numbers 0 to 3 with every flag value. This covers register 0, equal and unequal numbers, and all priority overlaps without depending on pipeline sequencing.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    SRC_RF  = 2'b00,
    SRC_WB  = 2'b01,
    SRC_MEM = 2'b10
  } fwd_src_e;
endpackage

// File: rtl/fwd_operand_sel.sv
module fwd_operand_sel
  import fwd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             mem_wen,
  input  logic [REG_W-1:0] wb_rd,
  input  logic             wb_wen,
  output fwd_src_e         sel
);
  logic src_live, hit_mem, hit_wb;

  assign src_live = (src != '0);
  assign hit_mem  = src_live && mem_wen && (mem_rd == src);
  assign hit_wb   = src_live && wb_wen && (wb_rd == src);

  always_comb begin
    if (hit_mem)     sel = SRC_MEM;
    else if (hit_wb) sel = SRC_WB;
    else             sel = SRC_RF;
  end

  p_zero_src_r4: assert property (@(posedge clk) disable iff (rst)
    (src == '0) |-> (sel == SRC_RF));
  p_wb_valid_r2: assert property (@(posedge clk) disable iff (rst)
    (sel == SRC_WB) |-> (wb_wen && wb_rd == src && !(mem_wen && mem_rd == src)));
  p_near_first_r3: assert property (@(posedge clk) disable iff (rst)
    (src != '0 && mem_wen && wb_wen && mem_rd == src && wb_rd == src) |-> (sel == SRC_MEM));
endmodule

// File: rtl/store_data_fwd.sv
module store_data_fwd #(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             st_en,
  input  logic [REG_W-1:0] st_reg,
  input  logic [REG_W-1:0] wb_rd,
  input  logic             wb_wen,
  output logic             use_wb
);
  assign use_wb = st_en && wb_wen && (st_reg != '0) && (st_reg == wb_rd);

  p_st_fwd_valid_r5: assert property (@(posedge clk) disable iff (rst)
    use_wb |-> (st_en && wb_wen && wb_rd != '0));
endmodule

// File: rtl/load_use_detect.sv
module load_use_detect #(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] id_rs,
  input  logic [REG_W-1:0] id_rt,
  input  logic             id_is_store,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             ex_wen,
  input  logic             ex_is_load,
  input  logic             branch_taken,
  output logic             stall,
  output logic             flush
);
  logic load_live, need_rs, need_rt;

  assign load_live = ex_is_load && ex_wen && (ex_rd != '0);
  assign need_rs   = (ex_rd == id_rs);
  // store data is picked up later in the memory stage, so rt of a store never stalls
  assign need_rt   = (ex_rd == id_rt) && !id_is_store;

  assign stall = load_live && (need_rs || need_rt);
  assign flush = branch_taken && !stall;

  p_store_rt_free_r7: assert property (@(posedge clk) disable iff (rst)
    (id_is_store && ex_rd != id_rs) |-> !stall);
  p_stall_beats_flush_r9: assert property (@(posedge clk) disable iff (rst)
    !(stall && flush));
  p_no_load_no_stall_r6: assert property (@(posedge clk) disable iff (rst)
    (!ex_is_load || !ex_wen) |-> !stall);
  p_flush_needs_branch_r8: assert property (@(posedge clk) disable iff (rst)
    flush |-> branch_taken);
endmodule

// File: rtl/fwd_hazard_unit.sv
module fwd_hazard_unit
  import fwd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] id_rs,
  input  logic [REG_W-1:0] id_rt,
  input  logic             id_is_store,
  input  logic [REG_W-1:0] ex_rs,
  input  logic [REG_W-1:0] ex_rt,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             ex_wen,
  input  logic             ex_is_load,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             mem_wen,
  input  logic             mem_is_store,
  input  logic [REG_W-1:0] mem_st_reg,
  input  logic [REG_W-1:0] wb_rd,
  input  logic             wb_wen,
  input  logic             branch_taken,
  output logic [1:0]       fwd_a,
  output logic [1:0]       fwd_b,
  output logic             st_fwd,
  output logic             pc_hold,
  output logic             ifid_hold,
  output logic             idex_bubble,
  output logic             ifid_flush
);
  localparam int N_OPS = 2;

  logic [REG_W-1:0] op_src [N_OPS];
  fwd_src_e         op_sel [N_OPS];
  logic             stall;

  assign op_src[0] = ex_rs;
  assign op_src[1] = ex_rt;

  for (genvar g = 0; g < N_OPS; g++) begin : g_op
    fwd_operand_sel #(.REG_W(REG_W)) u_sel (
      .clk     (clk),
      .rst     (rst),
      .src     (op_src[g]),
      .mem_rd  (mem_rd),
      .mem_wen (mem_wen),
      .wb_rd   (wb_rd),
      .wb_wen  (wb_wen),
      .sel     (op_sel[g])
    );
  end

  assign fwd_a = op_sel[0];
  assign fwd_b = op_sel[1];

  store_data_fwd #(.REG_W(REG_W)) u_st (
    .clk    (clk),
    .rst    (rst),
    .st_en  (mem_is_store),
    .st_reg (mem_st_reg),
    .wb_rd  (wb_rd),
    .wb_wen (wb_wen),
    .use_wb (st_fwd)
  );

  load_use_detect #(.REG_W(REG_W)) u_lu (
    .clk          (clk),
    .rst          (rst),
    .id_rs        (id_rs),
    .id_rt        (id_rt),
    .id_is_store  (id_is_store),
    .ex_rd        (ex_rd),
    .ex_wen       (ex_wen),
    .ex_is_load   (ex_is_load),
    .branch_taken (branch_taken),
    .stall        (stall),
    .flush        (ifid_flush)
  );

  assign pc_hold     = stall;
  assign ifid_hold   = stall;
  assign idex_bubble = stall;

  p_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (!ex_wen && !mem_wen && !wb_wen && !branch_taken)
      |-> (fwd_a == 2'b00 && fwd_b == 2'b00 && !st_fwd && !pc_hold && !ifid_flush));
  p_mem_hit_a_r1: assert property (@(posedge clk) disable iff (rst)
    (ex_rs != '0 && mem_wen && mem_rd == ex_rs) |-> (fwd_a == 2'b10));
endmodule

// File: tb/fwd_hazard_unit_test.sv
`timescale 1ns/1ps
module fwd_hazard_unit_test;
  localparam int REG_W = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [REG_W-1:0] id_rs = '0, id_rt = '0, ex_rs = '0, ex_rt = '0, ex_rd = '0;
  logic [REG_W-1:0] mem_rd = '0, mem_st_reg = '0, wb_rd = '0;
  logic id_is_store = 0, ex_wen = 0, ex_is_load = 0, mem_wen = 0, mem_is_store = 0;
  logic wb_wen = 0, branch_taken = 0;
  logic [1:0] fwd_a, fwd_b;
  logic st_fwd, pc_hold, ifid_hold, idex_bubble, ifid_flush;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  fwd_hazard_unit #(.REG_W(REG_W)) uut (
    .clk(clk), .rst(rst), .id_rs(id_rs), .id_rt(id_rt), .id_is_store(id_is_store),
    .ex_rs(ex_rs), .ex_rt(ex_rt), .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_is_load(ex_is_load),
    .mem_rd(mem_rd), .mem_wen(mem_wen), .mem_is_store(mem_is_store), .mem_st_reg(mem_st_reg),
    .wb_rd(wb_rd), .wb_wen(wb_wen), .branch_taken(branch_taken),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .st_fwd(st_fwd), .pc_hold(pc_hold),
    .ifid_hold(ifid_hold), .idex_bubble(idex_bubble), .ifid_flush(ifid_flush)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_sel(int s, int mr, int mw, int wr, int ww);
    if (s != 0 && mw == 1 && mr == s) return 2;
    if (s != 0 && ww == 1 && wr == s) return 1;
    return 0;
  endfunction

  function automatic string sel_tag(int s, int wr, int ww, int e);
    if (e == 2 && s != 0 && ww == 1 && wr == s) return "R3";
    if (e == 2) return "R1";
    if (e == 1) return "R2";
    return "R4";
  endfunction

  initial begin
    #(5.0 * 200000);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    // R10: quiet pipeline under reset
    chk("R10 fwd_a", fwd_a, 0);
    chk("R10 fwd_b", fwd_b, 0);
    chk("R10 st_fwd", st_fwd, 0);
    chk("R10 stall", {pc_hold, ifid_hold, idex_bubble}, 0);
    chk("R10 flush", ifid_flush, 0);
    @(negedge clk);
    rst = 1'b0;

    // R1..R4: execute operand selection sweep
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int m = 0; m < 4; m++)
          for (int w = 0; w < 4; w++)
            for (int fl = 0; fl < 4; fl++) begin
              int ea, eb;
              @(negedge clk);
              ex_rs = REG_W'(a); ex_rt = REG_W'(b);
              mem_rd = REG_W'(m); wb_rd = REG_W'(w);
              mem_wen = fl[0]; wb_wen = fl[1];
              #1;
              ea = exp_sel(a, m, fl[0], w, fl[1]);
              eb = exp_sel(b, m, fl[0], w, fl[1]);
              chk({sel_tag(a, w, fl[1], ea), " fwd_a"}, fwd_a, ea);
              chk({sel_tag(b, w, fl[1], eb), " fwd_b"}, fwd_b, eb);
            end
    @(negedge clk);
    ex_rs = '0; ex_rt = '0; mem_rd = '0; mem_wen = 0;

    // R5: store data from write-back
    for (int s = 0; s < 4; s++)
      for (int w = 0; w < 4; w++)
        for (int fl = 0; fl < 4; fl++) begin
          int e;
          @(negedge clk);
          mem_st_reg = REG_W'(s); wb_rd = REG_W'(w);
          mem_is_store = fl[0]; wb_wen = fl[1];
          #1;
          e = (fl == 3 && s != 0 && s == w) ? 1 : 0;
          chk("R5 st_fwd", st_fwd, e);
        end
    @(negedge clk);
    mem_st_reg = '0; wb_rd = '0; mem_is_store = 0; wb_wen = 0;

    // R6..R9: load-use stall and branch flush
    for (int rs = 0; rs < 4; rs++)
      for (int rt = 0; rt < 4; rt++)
        for (int rd = 0; rd < 4; rd++)
          for (int fl = 0; fl < 16; fl++) begin
            int es, ef;
            string tg;
            @(negedge clk);
            id_rs = REG_W'(rs); id_rt = REG_W'(rt); ex_rd = REG_W'(rd);
            ex_wen = fl[0]; ex_is_load = fl[1]; id_is_store = fl[2]; branch_taken = fl[3];
            #1;
            es = (fl[0] && fl[1] && rd != 0 && (rd == rs || (rd == rt && !fl[2]))) ? 1 : 0;
            ef = (fl[3] && es == 0) ? 1 : 0;
            if (fl[2] && rd == rt && rd != rs) tg = "R7";
            else if (fl[3] && es == 1) tg = "R9";
            else if (fl[3]) tg = "R8";
            else tg = "R6";
            chk({tg, " pc_hold"}, pc_hold, es);
            chk({tg, " ifid_hold"}, ifid_hold, es);
            chk({tg, " idex_bubble"}, idex_bubble, es);
            chk({tg, " ifid_flush"}, ifid_flush, ef);
          end

    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule